// File: doc/BRIEF.md
# Coin-Accumulating Vend Controller

This block adds up the value of coins as they are deposited and raises a one-cycle vend pulse once the running sum reaches the price of the item. A coin is reported by a one-cycle strobe that comes with an 8-bit value. The price is an 8-bit input that the block compares against the running sum on every cycle. After each vend, the sum returns to zero and the block is ready for the next customer.

The block is built in two parts. The datapath holds the running-sum register, which has load and clear controls, a capture register for the value of the last coin, an adder and a less-than comparator. A four-state controller (Init, Wait, Add, Vend) sees only one status bit from the datapath, "sum below price", and drives the load strobe, the clear strobe and the vend output. Parameters select whether the adder and comparator are written behaviourally or as explicit bit-sliced chains.

Top module: `coin_vend_top`

## Requirements
- R1: A synchronous active-high reset puts the controller in Init, zeroes the running sum and holds the vend output low. After reset is released, the sum starts again from zero.
- R2: Init lasts exactly one cycle. During it the clear strobe is active and vend is low, and the controller then moves to Wait.
- R3: A coin strobe seen in Wait moves the controller to Add on the next cycle. In Add, the sum is loaded with sum plus the value that came with that strobe, and the controller returns to Wait one cycle later.
- R4: The addition wraps modulo 2^8, with no overflow indication. For example, 200 + 100 gives 44.
- R5: In Wait with no coin strobe, the controller stays in Wait while sum < price. When sum >= price it enters Vend on the next cycle, so a sum equal to the price vends.
- R6: A coin strobe in Wait takes priority over the vend check. The coin is added first, even when the sum already reaches the price.
- R7: Vend lasts exactly one cycle with the vend output high, followed by Init and then Wait with a zero sum.
- R8: A coin strobe that arrives while the controller is in Add, Vend or Init is ignored and does not change the sum.
- R9: The load and clear strobes are never active in the same cycle. The sum holds its value in every cycle where neither is active.
- R10: The price is compared on every cycle in Wait. Lowering the price below the current sum causes a vend one cycle later.
- R11: With a price of 0 and no coins, the block vends every third cycle (Vend, Init, Wait, Vend, and so on).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_in | input | 1 | One-cycle strobe per deposited coin |
| coin_val | input | 8 | Value of the coin, valid with coin_in |
| price | input | 8 | Price of the item |
| vend_out | output | 1 | One-cycle vend pulse |

## Verification
The assertions check on every cycle that load and clear never overlap, that the sum holds when neither strobe is active, that a load adds the captured coin value, that a clear zeroes the sum, and that vend is a single cycle followed by Init. They also check that a coin seen in Wait always leads to a load, and that Wait with no coin and the sum at or above the price always leads to a vend. Only the bench scenarios show the end-to-end behaviour at the ports: the exact cycle of the vend after a coin sequence, wrap-around of the sum, coins ignored outside Wait, price changes taking effect, the three-cycle loop when the price is zero, and the sum starting over after a mid-sequence reset.

// File: rtl/vend_pkg.sv
package vend_pkg;
   typedef enum logic [1:0] {
      ST_INIT = 2'd0,
      ST_WAIT = 2'd1,
      ST_ADD  = 2'd2,
      ST_VEND = 2'd3
   } vend_state_e;

   localparam int unsigned STYLE_BEHAV = 0;
   localparam int unsigned STYLE_CHAIN = 1;
endpackage

// File: rtl/vend_adder.sv
module vend_adder #(
   parameter int unsigned W     = 8,
   parameter int unsigned STYLE = vend_pkg::STYLE_CHAIN
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o
);
   if (W < 2) begin : g_bad_w
      $error("vend_adder: W must be at least 2");
   end
   if (STYLE > vend_pkg::STYLE_CHAIN) begin : g_bad_style
      $error("vend_adder: unknown STYLE");
   end

   if (STYLE == vend_pkg::STYLE_BEHAV) begin : g_behav
      assign sum_o = a_i + b_i;
   end else begin : g_chain
      logic [W-1:0] cy;
      assign cy[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
         if (i < W - 1) begin : g_cy
            assign cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
         end
      end
   end
endmodule

// File: rtl/vend_less.sv
module vend_less #(
   parameter int unsigned W     = 8,
   parameter int unsigned STYLE = vend_pkg::STYLE_CHAIN
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         lt_o
);
   if (W < 2) begin : g_bad_w
      $error("vend_less: W must be at least 2");
   end

   if (STYLE == vend_pkg::STYLE_BEHAV) begin : g_behav
      assign lt_o = (a_i < b_i);
   end else begin : g_chain
      // borrow of a - b, rippled from the LSB; final borrow means a < b
      logic [W:0] bw;
      assign bw[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign bw[i+1] = (~a_i[i] & b_i[i]) | (~(a_i[i] ^ b_i[i]) & bw[i]);
      end
      assign lt_o = bw[W];
   end
endmodule

// File: rtl/vend_datapath.sv
module vend_datapath #(
   parameter int unsigned W         = 8,
   parameter int unsigned ADD_STYLE = vend_pkg::STYLE_CHAIN,
   parameter int unsigned CMP_STYLE = vend_pkg::STYLE_CHAIN
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         coin_in,
   input  logic [W-1:0] coin_val,
   input  logic [W-1:0] price,
   input  logic         ld,
   input  logic         clr,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] held_o,
   output logic         below_o
);
   logic [W-1:0] sum_q, held_q, next_sum;

   // value of the latest coin, consumed by the load one cycle later
   always_ff @(posedge clk) begin
      if (rst)          held_q <= '0;
      else if (coin_in) held_q <= coin_val;
   end

   always_ff @(posedge clk) begin
      if (rst || clr) sum_q <= '0;
      else if (ld)    sum_q <= next_sum;
   end

   vend_adder #(.W(W), .STYLE(ADD_STYLE)) u_add (
      .a_i(sum_q), .b_i(held_q), .sum_o(next_sum)
   );

   vend_less #(.W(W), .STYLE(CMP_STYLE)) u_cmp (
      .a_i(sum_q), .b_i(price), .lt_o(below_o)
   );

   assign sum_o  = sum_q;
   assign held_o = held_q;
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
   import vend_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic coin_in,
   input  logic below,
   output logic ld,
   output logic clr,
   output logic vend,
   output logic in_wait
);
   vend_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_INIT: st_d = ST_WAIT;
         ST_WAIT: begin
            if (coin_in)     st_d = ST_ADD;
            else if (!below) st_d = ST_VEND;
            else             st_d = ST_WAIT;
         end
         ST_ADD:  st_d = ST_WAIT;
         ST_VEND: st_d = ST_INIT;
         default: st_d = ST_INIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_INIT;
      else     st_q <= st_d;
   end

   // Moore outputs, one state each
   assign clr     = (st_q == ST_INIT);
   assign ld      = (st_q == ST_ADD);
   assign vend    = (st_q == ST_VEND);
   assign in_wait = (st_q == ST_WAIT);
endmodule

// File: rtl/coin_vend_top.sv
module coin_vend_top #(
   parameter int unsigned W         = 8,
   parameter int unsigned ADD_STYLE = vend_pkg::STYLE_CHAIN,
   parameter int unsigned CMP_STYLE = vend_pkg::STYLE_CHAIN
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         coin_in,
   input  logic [W-1:0] coin_val,
   input  logic [W-1:0] price,
   output logic         vend_out
);
   logic         ld_w, clr_w, below_w, wait_w;
   logic [W-1:0] sum_w, held_w;

   vend_ctrl u_ctrl (
      .clk(clk), .rst(rst), .coin_in(coin_in), .below(below_w),
      .ld(ld_w), .clr(clr_w), .vend(vend_out), .in_wait(wait_w)
   );

   vend_datapath #(.W(W), .ADD_STYLE(ADD_STYLE), .CMP_STYLE(CMP_STYLE)) u_dp (
      .clk(clk), .rst(rst), .coin_in(coin_in), .coin_val(coin_val),
      .price(price), .ld(ld_w), .clr(clr_w),
      .sum_o(sum_w), .held_o(held_w), .below_o(below_w)
   );
endmodule

// File: rtl/vend_checker.sv
module vend_checker #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         coin_in,
   input logic         vend_out,
   input logic         ld,
   input logic         clr,
   input logic         below,
   input logic         in_wait,
   input logic [W-1:0] sum,
   input logic [W-1:0] held
);
   assert_ld_clr_excl_R9: assert property (@(posedge clk) disable iff (rst)
      !(ld && clr));

   assert_sum_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (!ld && !clr) |=> $stable(sum));

   assert_load_adds_R3: assert property (@(posedge clk) disable iff (rst)
      ld |=> (sum == W'($past(sum) + $past(held))));

   assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
      clr |=> (sum == '0 && in_wait && !vend_out));

   assert_vend_single_R7: assert property (@(posedge clk) disable iff (rst)
      vend_out |=> (!vend_out && clr));

   assert_coin_first_R6: assert property (@(posedge clk) disable iff (rst)
      (in_wait && coin_in) |=> (ld && !vend_out));

   assert_vend_when_met_R5: assert property (@(posedge clk) disable iff (rst)
      (in_wait && !coin_in && !below) |=> vend_out);

   assert_stay_below_R5: assert property (@(posedge clk) disable iff (rst)
      (in_wait && !coin_in && below) |=> (in_wait && !vend_out));
endmodule

bind coin_vend_top vend_checker #(.W(W)) u_chk (
   .clk(clk), .rst(rst), .coin_in(coin_in), .vend_out(vend_out),
   .ld(ld_w), .clr(clr_w), .below(below_w), .in_wait(wait_w),
   .sum(sum_w), .held(held_w)
);

// File: tb/sim_coin_vend_top.sv
`timescale 1ns/100ps
module sim_coin_vend_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       coin_in = 1'b0;
   logic [7:0] coin_val = 8'd0;
   logic [7:0] price = 8'd50;
   logic       vend_out;

   int checks = 0;
   int failures = 0;
   int exp_sum = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   coin_vend_top u0 (
      .clk(clk), .rst(rst), .coin_in(coin_in), .coin_val(coin_val),
      .price(price), .vend_out(vend_out)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: vend_out=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // ends at a negedge with the controller in Wait and the sum zero
   task automatic do_reset(input string tag);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(vend_out, 1'b0, tag);
      @(negedge clk);
      chk(vend_out, 1'b0, tag);
      rst = 1'b0;
      @(negedge clk);
      chk(vend_out, 1'b0, tag);
      exp_sum = 0;
   endtask

   // called in Wait; ends in Wait with the sum updated
   task automatic feed(input int val, input string tag);
      coin_in = 1'b1;
      coin_val = 8'(val);
      @(negedge clk);
      coin_in = 1'b0;
      chk(vend_out, 1'b0, tag);
      @(negedge clk);
      chk(vend_out, 1'b0, tag);
      exp_sum = (exp_sum + val) % 256;
   endtask

   // one cycle in Wait: vend if the model's sum reaches the price
   task automatic settle(input string tag);
      @(negedge clk);
      if (exp_sum >= int'(price)) begin
         chk(vend_out, 1'b1, tag);
         @(negedge clk);
         chk(vend_out, 1'b0, tag);
         @(negedge clk);
         chk(vend_out, 1'b0, tag);
         exp_sum = 0;
      end else begin
         chk(vend_out, 1'b0, tag);
      end
   endtask

   task automatic t_basic();
      price = 8'd25;
      feed(10, "R3 coin 10");  settle("R5 sum 10 below 25");
      feed(10, "R3 coin 10");  settle("R5 sum 20 below 25");
      feed(5,  "R3 coin 5");   settle("R5 sum equals price vends");
      settle("R7 back in Wait, sum zero");
   endtask

   task automatic t_wrap();
      price = 8'd250;
      feed(200, "R4 coin 200"); settle("R4 sum 200");
      feed(100, "R4 coin 100"); settle("R4 wrapped sum 44 below 250");
      feed(206, "R4 coin 206"); settle("R4 sum 250 vends");
   endtask

   task automatic t_priority();
      price = 8'd50;
      feed(40, "R6 coin 40"); settle("R6 sum 40");
      feed(20, "R6 coin 20");
      feed(5,  "R6 coin taken before vend");
      settle("R6 vend after second coin");
   endtask

   task automatic t_ignored();
      price = 8'd10;
      feed(15, "R8 coin 15");
      @(negedge clk);
      chk(vend_out, 1'b1, "R7 vend pulse");
      coin_in = 1'b1; coin_val = 8'd50;
      @(negedge clk);
      chk(vend_out, 1'b0, "R7 Init after vend");
      coin_val = 8'd60;
      @(negedge clk);
      coin_in = 1'b0;
      chk(vend_out, 1'b0, "R2 Wait after Init");
      exp_sum = 0;
      settle("R8 coins in Vend/Init ignored");
      feed(5, "R8 coin 5"); settle("R8 sum is 5 only");
      feed(5, "R8 coin 5"); settle("R8 sum 10 vends");
   endtask

   task automatic t_price_change();
      price = 8'd50;
      feed(30, "R10 coin 30"); settle("R10 sum 30 below 50");
      price = 8'd20;
      settle("R10 lowered price vends");
   endtask

   task automatic t_zero_price();
      price = 8'd0;
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); chk(vend_out, 1'b1, "R11 vend");
         @(negedge clk); chk(vend_out, 1'b0, "R11 Init");
         @(negedge clk); chk(vend_out, 1'b0, "R11 Wait");
      end
      price = 8'd100;
      exp_sum = 0;
      settle("R11 price restored, no vend");
   endtask

   task automatic t_mid_reset();
      price = 8'd50;
      feed(30, "R1 coin 30");
      do_reset("R1 reset mid-sequence");
      feed(30, "R1 coin 30 after reset");
      settle("R1 sum restarted at 30");
   endtask

   initial begin
      do_reset("R1 reset state");
      t_basic();
      t_wrap();
      t_priority();
      t_ignored();
      t_price_change();
      t_zero_price();
      t_mid_reset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule